// File: doc/BRIEF.md
# Display Controller Register and Interrupt Unit

This unit is the software-visible register bank of a display controller. A simple word-oriented bus gives write and read access to six 32-bit registers: control, three timing words, status and subpanel. Control writes are split into decoded fields that drive the rest of the controller: load mode, TFT select, monochrome select, enable and a two-bit interrupt mask. Reads return the stored fields with some fields mirrored and some fixed bits forced to one.

The unit keeps three sticky event flags: frame-done, palette-done and sync-error. The frame engine sets palette-done and sync-error with single-cycle pulses. Enable transitions written through the control register update the flags and are reported back to the engine as single-cycle pulses. A registered, level-sensitive interrupt is built from the flags and the mask. Sync-error always reaches the interrupt, whatever the mask says.

Top module: `lcd_regs_top`

## Requirements
- R1: Byte offsets 0x00 control, 0x04 timing0, 0x08 timing1, 0x0C timing2, 0x10 status and 0x14 subpanel are decoded. Any other offset, including an unaligned one, reads 0 and its writes change no register. `busRdData` loads the selected value at the edge where `busRdEn` is high and holds it otherwise.
- R2: A control write captures load mode from bits 21:20, TFT from bit 7, mask from bits 4:3, mono from bit 1, enable from bit 0, and keeps the write data ANDed with 0x01CFF300. A control read returns the OR of TFT<<23, load mode<<20, TFT<<7, mask<<3, mono<<1, enable, the kept bits and 0xFE000C34. `loadMode`, `tftSel`, `monoSel` and `dispEnable` show the stored fields.
- R3: Timing0 and timing1 keep bits 31:10 as written and store bits 9:0 plus one in an 11-bit length. A read returns the kept upper bits in 31:10 and the low 10 bits of (length - 1) in 9:0. A timing0 read also ORs in 0xF.
- R4: Timing2 stores the whole word and reads back ORed with 0xFC000000. Subpanel stores the write data ANDed with 0xA1FFFFFF.
- R5: A status read returns palette-done at bit 6, sync-error at bit 2 and frame-done at bit 0, with all other bits zero. A write to status changes no flag.
- R6: A high `palLoadedPulse` sets palette-done and a high `syncErrPulse` sets sync-error at the next edge. Both flags then stay set until an enable transition clears them. A pulse in the same cycle as a clearing transition wins.
- R7: `irq` is a register loaded each cycle with (frame-done AND mask bit 0) OR (palette-done AND mask bit 1) OR sync-error. It therefore follows a flag or mask change one cycle later.
- R8: A control write that moves enable from 1 to 0 clears sync-error. It also sets frame-done unless the newly written load mode equals 1.
- R9: A control write that moves enable from 0 to 1 while `engineIdle` is high clears frame-done and palette-done. When `engineIdle` is low, the flags are left as they are.
- R10: A transition happens only when the written enable bit differs from the stored one. In the cycle after such a write, `enableRise` or `enableFall` is high for exactly one cycle. Rewriting the same enable value gives no pulse and no flag change.
- R11: After reset, every field, flag, `irq` and `busRdData` is 0. Control then reads 0xFE000C34, timing0 and timing1 read 0x3FF, timing2 reads 0xFC000000, and status and subpanel read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| busAddr | input | ADDR_W | Byte address of the access |
| busWrData | input | 32 | Write data |
| busWrEn | input | 1 | Write strobe, one cycle per write |
| busRdEn | input | 1 | Read strobe; data appears the following cycle |
| busRdData | output | 32 | Registered read data |
| engineIdle | input | 1 | Frame engine has no frame in progress |
| palLoadedPulse | input | 1 | Engine finished loading the palette |
| syncErrPulse | input | 1 | Engine detected a synchronisation error |
| enableRise | output | 1 | One-cycle pulse after an enable 0 to 1 write |
| enableFall | output | 1 | One-cycle pulse after an enable 1 to 0 write |
| dispEnable | output | 1 | Stored enable field |
| loadMode | output | 2 | Stored load mode field |
| tftSel | output | 1 | Stored TFT select |
| monoSel | output | 1 | Stored monochrome select |
| irq | output | 1 | Registered level interrupt |

## Verification
The checker assumes that `palLoadedPulse` and `syncErrPulse` only change flags through the pulse path. It also assumes that a write to offset 0x00 is the only way enable can move. A flag is therefore expected to hold in any cycle without a control write and without its pulse. The stimulus drives every bus access and event pulse for exactly one cycle, on the falling edge. It never lets an event pulse coincide with a control write, so expected flag values follow from the requirements in a fixed order.

// File: rtl/lcd_regs_pkg.sv
package lcd_regs_pkg;

  localparam int DATA_W = 32;

  localparam logic [DATA_W-1:0] CTRL_KEEP_MASK = 32'h01CF_F300;
  localparam logic [DATA_W-1:0] CTRL_READ_ONES = 32'hFE00_0C34;
  localparam logic [DATA_W-1:0] TIM0_READ_ONES = 32'h0000_000F;
  localparam logic [DATA_W-1:0] TIM2_READ_ONES = 32'hFC00_0000;
  localparam logic [DATA_W-1:0] SUBP_KEEP_MASK = 32'hA1FF_FFFF;

  localparam int OFF_CTRL = 'h00;
  localparam int OFF_TIM0 = 'h04;
  localparam int OFF_TIM1 = 'h08;
  localparam int OFF_TIM2 = 'h0C;
  localparam int OFF_STAT = 'h10;
  localparam int OFF_SUBP = 'h14;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_CTRL,
    SEL_TIM0,
    SEL_TIM1,
    SEL_TIM2,
    SEL_STAT,
    SEL_SUBP
  } rdSel_e;

  typedef struct packed {
    logic   wrCtrl;
    logic   wrTim0;
    logic   wrTim1;
    logic   wrTim2;
    logic   wrSubp;
    logic   rdStrobe;
    rdSel_e rdSel;
  } regStrobes_t;

endpackage

// File: rtl/lcd_regs_ctrl.sv
module lcd_regs_ctrl
  import lcd_regs_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic              wrEnableBit,
  input  logic [1:0]        wrLoadMode,
  input  logic              curEnable,
  input  logic [1:0]        curMask,
  input  logic              engineIdle,
  input  logic              palLoadedPulse,
  input  logic              syncErrPulse,
  output regStrobes_t       strobes,
  output logic              frameDone,
  output logic              paletteDone,
  output logic              syncErr,
  output logic              irq,
  output logic              enableRise,
  output logic              enableFall
);

  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFF_CTRL);
  localparam logic [ADDR_W-1:0] A_TIM0 = ADDR_W'(OFF_TIM0);
  localparam logic [ADDR_W-1:0] A_TIM1 = ADDR_W'(OFF_TIM1);
  localparam logic [ADDR_W-1:0] A_TIM2 = ADDR_W'(OFF_TIM2);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFF_STAT);
  localparam logic [ADDR_W-1:0] A_SUBP = ADDR_W'(OFF_SUBP);

  rdSel_e sel;
  logic   goRise;
  logic   goFall;

  always_comb begin
    unique case (busAddr)
      A_CTRL:  sel = SEL_CTRL;
      A_TIM0:  sel = SEL_TIM0;
      A_TIM1:  sel = SEL_TIM1;
      A_TIM2:  sel = SEL_TIM2;
      A_STAT:  sel = SEL_STAT;
      A_SUBP:  sel = SEL_SUBP;
      default: sel = SEL_NONE;
    endcase
  end

  always_comb begin
    strobes.wrCtrl   = busWrEn && (sel == SEL_CTRL);
    strobes.wrTim0   = busWrEn && (sel == SEL_TIM0);
    strobes.wrTim1   = busWrEn && (sel == SEL_TIM1);
    strobes.wrTim2   = busWrEn && (sel == SEL_TIM2);
    strobes.wrSubp   = busWrEn && (sel == SEL_SUBP);
    strobes.rdStrobe = busRdEn;
    strobes.rdSel    = sel;
  end

  // an enable transition needs a written bit that differs from the stored one
  assign goRise = strobes.wrCtrl && wrEnableBit && !curEnable;
  assign goFall = strobes.wrCtrl && !wrEnableBit && curEnable;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      frameDone   <= 1'b0;
      paletteDone <= 1'b0;
      syncErr     <= 1'b0;
      enableRise  <= 1'b0;
      enableFall  <= 1'b0;
    end else begin
      enableRise <= goRise;
      enableFall <= goFall;
      if (goFall) begin
        syncErr <= 1'b0;
        if (wrLoadMode != 2'd1) frameDone <= 1'b1;
      end
      if (goRise && engineIdle) begin
        frameDone   <= 1'b0;
        paletteDone <= 1'b0;
      end
      // event pulses are applied last so they win over a clear
      if (palLoadedPulse) paletteDone <= 1'b1;
      if (syncErrPulse)   syncErr     <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= (frameDone & curMask[0]) | (paletteDone & curMask[1]) | syncErr;
  end

endmodule

// File: rtl/lcd_regs_dp.sv
module lcd_regs_dp
  import lcd_regs_pkg::*;
#(
  parameter int LEN_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  regStrobes_t       strobes,
  input  logic [DATA_W-1:0] busWrData,
  input  logic              frameDone,
  input  logic              paletteDone,
  input  logic              syncErr,
  output logic [DATA_W-1:0] busRdData,
  output logic              ctrlEnable,
  output logic [1:0]        ctrlMask,
  output logic [1:0]        ctrlLoadMode,
  output logic              ctrlTft,
  output logic              ctrlMono
);

  localparam int HI_W  = DATA_W - LEN_W;
  localparam int CNT_W = LEN_W + 1;

  logic [DATA_W-1:0] ctrlKeep;
  logic [DATA_W-1:0] tim2Word;
  logic [DATA_W-1:0] subpWord;
  logic [HI_W-1:0]   timHi  [2];
  logic [CNT_W-1:0]  timLen [2];
  logic [CNT_W-1:0]  timBack[2];
  logic [DATA_W-1:0] timRead[2];
  logic [DATA_W-1:0] rdMux;
  logic [1:0]        timWr;

  assign timWr = {strobes.wrTim1, strobes.wrTim0};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrlEnable   <= 1'b0;
      ctrlMask     <= '0;
      ctrlLoadMode <= '0;
      ctrlTft      <= 1'b0;
      ctrlMono     <= 1'b0;
      ctrlKeep     <= '0;
    end else if (strobes.wrCtrl) begin
      ctrlLoadMode <= busWrData[21:20];
      ctrlTft      <= busWrData[7];
      ctrlMask     <= busWrData[4:3];
      ctrlMono     <= busWrData[1];
      ctrlEnable   <= busWrData[0];
      ctrlKeep     <= busWrData & CTRL_KEEP_MASK;
    end
  end

  for (genvar t = 0; t < 2; t++) begin : g_tim
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        timHi[t]  <= '0;
        timLen[t] <= '0;
      end else if (timWr[t]) begin
        timHi[t]  <= busWrData[DATA_W-1:LEN_W];
        timLen[t] <= {1'b0, busWrData[LEN_W-1:0]} + CNT_W'(1);
      end
    end
    assign timBack[t] = timLen[t] - CNT_W'(1);
    assign timRead[t] = {timHi[t], timBack[t][LEN_W-1:0]};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tim2Word <= '0;
      subpWord <= '0;
    end else begin
      if (strobes.wrTim2) tim2Word <= busWrData;
      if (strobes.wrSubp) subpWord <= busWrData & SUBP_KEEP_MASK;
    end
  end

  always_comb begin
    unique case (strobes.rdSel)
      SEL_CTRL: rdMux = CTRL_READ_ONES | ctrlKeep
                      | (DATA_W'(ctrlTft) << 23) | (DATA_W'(ctrlLoadMode) << 20)
                      | (DATA_W'(ctrlTft) << 7)  | (DATA_W'(ctrlMask) << 3)
                      | (DATA_W'(ctrlMono) << 1) | DATA_W'(ctrlEnable);
      SEL_TIM0: rdMux = timRead[0] | TIM0_READ_ONES;
      SEL_TIM1: rdMux = timRead[1];
      SEL_TIM2: rdMux = tim2Word | TIM2_READ_ONES;
      SEL_STAT: rdMux = (DATA_W'(paletteDone) << 6) | (DATA_W'(syncErr) << 2)
                      | DATA_W'(frameDone);
      SEL_SUBP: rdMux = subpWord;
      default:  rdMux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                 busRdData <= '0;
    else if (strobes.rdStrobe)  busRdData <= rdMux;
  end

endmodule

// File: rtl/lcd_regs_top.sv
module lcd_regs_top
  import lcd_regs_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LEN_W  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWrData,
  input  logic              busWrEn,
  input  logic              busRdEn,
  output logic [31:0]       busRdData,
  input  logic              engineIdle,
  input  logic              palLoadedPulse,
  input  logic              syncErrPulse,
  output logic              enableRise,
  output logic              enableFall,
  output logic              dispEnable,
  output logic [1:0]        loadMode,
  output logic              tftSel,
  output logic              monoSel,
  output logic              irq
);

  regStrobes_t strobes;
  logic        frameDone;
  logic        paletteDone;
  logic        syncErr;
  logic [1:0]  ctrlMask;

  lcd_regs_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk            (clk),
    .rst_n          (rst_n),
    .busAddr        (busAddr),
    .busWrEn        (busWrEn),
    .busRdEn        (busRdEn),
    .wrEnableBit    (busWrData[0]),
    .wrLoadMode     (busWrData[21:20]),
    .curEnable      (dispEnable),
    .curMask        (ctrlMask),
    .engineIdle     (engineIdle),
    .palLoadedPulse (palLoadedPulse),
    .syncErrPulse   (syncErrPulse),
    .strobes        (strobes),
    .frameDone      (frameDone),
    .paletteDone    (paletteDone),
    .syncErr        (syncErr),
    .irq            (irq),
    .enableRise     (enableRise),
    .enableFall     (enableFall)
  );

  lcd_regs_dp #(.LEN_W(LEN_W)) u_dp (
    .clk          (clk),
    .rst_n        (rst_n),
    .strobes      (strobes),
    .busWrData    (busWrData),
    .frameDone    (frameDone),
    .paletteDone  (paletteDone),
    .syncErr      (syncErr),
    .busRdData    (busRdData),
    .ctrlEnable   (dispEnable),
    .ctrlMask     (ctrlMask),
    .ctrlLoadMode (loadMode),
    .ctrlTft      (tftSel),
    .ctrlMono     (monoSel)
  );

endmodule

// File: rtl/lcd_regs_chk.sv
module lcd_regs_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWrEn,
  input logic              palLoadedPulse,
  input logic              syncErrPulse,
  input logic              frameDone,
  input logic              paletteDone,
  input logic              syncErr,
  input logic [1:0]        ctrlMask,
  input logic              irq,
  input logic              enableRise,
  input logic              enableFall,
  input logic              dispEnable
);

  a_r7_irq_follows: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> irq == (($past(frameDone) & $past(ctrlMask[0]))
                   | ($past(paletteDone) & $past(ctrlMask[1]))
                   | $past(syncErr)));

  a_r8_fall_clears_sync: assert property (@(posedge clk) disable iff (!rst_n)
    (enableFall && !$past(syncErrPulse)) |-> !syncErr);

  a_r10_pulse_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(enableRise && enableFall));

  a_r10_rise_level: assert property (@(posedge clk) disable iff (!rst_n)
    enableRise |-> dispEnable);

  a_r10_fall_level: assert property (@(posedge clk) disable iff (!rst_n)
    enableFall |-> !dispEnable);

  a_r6_sync_sets: assert property (@(posedge clk) disable iff (!rst_n)
    syncErrPulse |=> syncErr);

  a_r5_palette_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!(busWrEn && busAddr == '0) && !palLoadedPulse) |=> $stable(paletteDone));

endmodule

bind lcd_regs_top lcd_regs_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .busAddr        (busAddr),
  .busWrEn        (busWrEn),
  .palLoadedPulse (palLoadedPulse),
  .syncErrPulse   (syncErrPulse),
  .frameDone      (frameDone),
  .paletteDone    (paletteDone),
  .syncErr        (syncErr),
  .ctrlMask       (ctrlMask),
  .irq            (irq),
  .enableRise     (enableRise),
  .enableFall     (enableFall),
  .dispEnable     (dispEnable)
);

// File: tb/lcd_regs_top_tb.sv
module lcd_regs_top_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  busAddr = '0;
  logic [31:0] busWrData = '0;
  logic        busWrEn = 1'b0;
  logic        busRdEn = 1'b0;
  logic [31:0] busRdData;
  logic        engineIdle = 1'b1;
  logic        palLoadedPulse = 1'b0;
  logic        syncErrPulse = 1'b0;
  logic        enableRise, enableFall, dispEnable, tftSel, monoSel, irq;
  logic [1:0]  loadMode;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  lcd_regs_top u_dut (
    .clk(clk), .rst_n(rst_n), .busAddr(busAddr), .busWrData(busWrData),
    .busWrEn(busWrEn), .busRdEn(busRdEn), .busRdData(busRdData),
    .engineIdle(engineIdle), .palLoadedPulse(palLoadedPulse),
    .syncErrPulse(syncErrPulse), .enableRise(enableRise), .enableFall(enableFall),
    .dispEnable(dispEnable), .loadMode(loadMode), .tftSel(tftSel),
    .monoSel(monoSel), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk); busWrEn = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); busAddr = a; busRdEn = 1'b1;
    @(negedge clk); busRdEn = 1'b0; d = busRdData;
  endtask

  task automatic rdChk(input string req, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(req, d, exp);
  endtask

  task automatic pulsePal();
    @(negedge clk); palLoadedPulse = 1'b1;
    @(negedge clk); palLoadedPulse = 1'b0;
  endtask

  task automatic pulseSync();
    @(negedge clk); syncErrPulse = 1'b1;
    @(negedge clk); syncErrPulse = 1'b0;
  endtask

  task automatic irqChk(input string req, input logic exp);
    @(negedge clk);
    chk(req, 32'(irq), 32'(exp));
  endtask

  task automatic testReset();
    chk("R11 irq", 32'(irq), 0);
    chk("R11 rdata", busRdData, 0);
    chk("R11 enable", 32'(dispEnable), 0);
    rdChk("R11 control", 8'h00, 32'hFE000C34);
    rdChk("R11 timing0", 8'h04, 32'h000003FF);
    rdChk("R11 timing1", 8'h08, 32'h000003FF);
    rdChk("R11 timing2", 8'h0C, 32'hFC000000);
    rdChk("R11 status", 8'h10, 32'h0);
    rdChk("R11 subpanel", 8'h14, 32'h0);
  endtask

  task automatic testControl();
    wr(8'h00, 32'hFFFFFFFE);
    rdChk("R2 control all ones", 8'h00, 32'hFFFFFFBE);
    chk("R2 loadMode", 32'(loadMode), 3);
    chk("R2 tft", 32'(tftSel), 1);
    chk("R2 mono", 32'(monoSel), 1);
    chk("R2 enable", 32'(dispEnable), 0);
    wr(8'h00, 32'h00000000);
    rdChk("R2 control zero", 8'h00, 32'hFE000C34);
  endtask

  task automatic testTiming();
    wr(8'h04, 32'hABCDE123);
    rdChk("R3 timing0", 8'h04, 32'hABCDE12F);
    wr(8'h08, 32'h12345678);
    rdChk("R3 timing1", 8'h08, 32'h12345678);
    wr(8'h04, 32'h00000400);
    rdChk("R3 timing0 field zero", 8'h04, 32'h0000040F);
    wr(8'h08, 32'h000003FF);
    rdChk("R3 timing1 field max", 8'h08, 32'h000003FF);
    wr(8'h0C, 32'h01234567);
    rdChk("R4 timing2", 8'h0C, 32'hFD234567);
    wr(8'h14, 32'hFFFFFFFF);
    rdChk("R4 subpanel", 8'h14, 32'hA1FFFFFF);
  endtask

  task automatic testUnmapped();
    wr(8'h18, 32'h5A5A5A5A);
    wr(8'h15, 32'h00000000);
    rdChk("R1 offset 0x18 reads zero", 8'h18, 32'h0);
    rdChk("R1 offset 0xFC reads zero", 8'hFC, 32'h0);
    rdChk("R1 unmapped write ignored", 8'h14, 32'hA1FFFFFF);
    @(negedge clk);
    chk("R1 rdata holds", busRdData, 32'hA1FFFFFF);
  endtask

  task automatic testFlags();
    engineIdle = 1'b1;
    wr(8'h00, 32'h00000001);
    chk("R10 rise pulse", 32'(enableRise), 1);
    chk("R10 no fall", 32'(enableFall), 0);
    @(negedge clk);
    chk("R10 rise one cycle", 32'(enableRise), 0);
    pulsePal();
    rdChk("R6 palette set", 8'h10, 32'h40);
    irqChk("R7 masked off", 1'b0);
    wr(8'h00, 32'h00000011);
    chk("R10 same value no pulse", 32'(enableRise | enableFall), 0);
    irqChk("R7 palette with mask bit1", 1'b1);
    wr(8'h10, 32'h00000000);
    rdChk("R5 status write ignored", 8'h10, 32'h40);
    wr(8'h00, 32'h00000010);
    chk("R10 fall pulse", 32'(enableFall), 1);
    rdChk("R8 fall sets frame", 8'h10, 32'h41);
    wr(8'h00, 32'h00000000);
    irqChk("R7 mask cleared", 1'b0);
    rdChk("R10 no transition keeps flags", 8'h10, 32'h41);
    pulseSync();
    rdChk("R6 sync set", 8'h10, 32'h45);
    irqChk("R7 sync ignores mask", 1'b1);
    engineIdle = 1'b0;
    wr(8'h00, 32'h00000001);
    rdChk("R9 busy rise keeps flags", 8'h10, 32'h45);
    wr(8'h00, 32'h00000000);
    rdChk("R8 fall clears sync", 8'h10, 32'h41);
    engineIdle = 1'b1;
    wr(8'h00, 32'h00000001);
    rdChk("R9 idle rise clears", 8'h10, 32'h00);
    irqChk("R7 all clear", 1'b0);
    wr(8'h00, 32'h00100000);
    rdChk("R8 load mode 1 no frame", 8'h10, 32'h00);
    wr(8'h00, 32'h00000001);
    wr(8'h00, 32'h00000008);
    rdChk("R8 fall with mask0", 8'h10, 32'h01);
    irqChk("R7 frame with mask bit0", 1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    testReset();
    testControl();
    testTiming();
    testUnmapped();
    testFlags();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule